// File: doc/BRIEF.md
# Vector Word Permutation Crossbar

This block moves data between a vector register file and a vector execution unit. It takes thirty-two 32-bit source lanes and produces thirty-two 32-bit result lanes. A 2-bit opcode selects the routing. Pass-through keeps every lane where it is. Permute gives each result lane its own 5-bit source index, so any mapping can be built, repeats included. Broadcast copies one chosen source lane to every result lane.

A single select bit chooses the source vector for all lanes at once: either the register-file data or an equally wide bypass vector. Each bit of every result lane comes from a fixed three-stage 32:1 select tree. The tree has a first rank of eight 4:1 selectors, a second rank of two 4:1 selectors and a final 2:1 selector. The block registers its result when the input is valid. It also presents the even-numbered and odd-numbered result lanes as two separate forwarding buses.

Top module: `vxbar_permute_xbar`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_data`, `fwd_even` and `fwd_odd` are cleared to zero at that edge.
- R2: With `opcode` = 2'b00 (pass-through), result lane i equals source lane i. Lane i of any 1024-bit bus occupies bits [32*i+31 : 32*i].
- R3: With `opcode` = 2'b01 (permute), result lane i equals source lane `perm_idx[5*i+4 : 5*i]`. Any mapping is allowed, including several result lanes reading the same source lane.
- R4: With `opcode` = 2'b10 (broadcast), every result lane equals source lane `bcast_idx`.
- R5: `opcode` = 2'b11 is reserved and behaves exactly like pass-through.
- R6: The source vector is `rf_data` when `src_sel` = 0 and `byp_data` when `src_sel` = 1, for all lanes together.
- R7: When `in_valid` is high at a clock edge, the routed result appears on `out_data` after that edge. `out_valid` equals the `in_valid` value sampled at the previous edge.
- R8: When `in_valid` is low at an edge, `out_data` keeps its value, whatever happens on the data, index, opcode and select inputs.
- R9: Word k of `fwd_even` (bits [32*k+31 : 32*k]) equals result lane 2k. Word k of `fwd_odd` equals result lane 2k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Loads the result register |
| src_sel | input | 1 | 0 = register-file data, 1 = bypass data |
| opcode | input | 2 | 00 pass, 01 permute, 10 broadcast, 11 reserved (pass) |
| perm_idx | input | 160 | Per-lane 5-bit source index for permute |
| bcast_idx | input | 5 | Source lane for broadcast |
| rf_data | input | 1024 | Register-file source lanes |
| byp_data | input | 1024 | Bypass source lanes |
| out_valid | output | 1 | Result valid |
| out_data | output | 1024 | Registered result lanes |
| fwd_even | output | 512 | Even result lanes 0,2,...,30 |
| fwd_odd | output | 512 | Odd result lanes 1,3,...,31 |

## Verification
Every routed result, its valid flag and both forwarding buses are due exactly one clock edge after the cycle in which `in_valid` is high. The bench drives inputs on a falling edge and compares all four outputs at the next falling edge, which falls between the loading edge and the one after it. For the hold case, the bench drops `in_valid`, scrambles every other input, and checks one edge later that the data is unchanged and the valid flag is low.

// File: rtl/vxbar_pkg.sv
package vxbar_pkg;

  localparam int unsigned XB_LANES = 32;
  localparam int unsigned XB_IDXW  = 5;

  typedef enum logic [1:0] {
    OP_PASS  = 2'b00,
    OP_PERM  = 2'b01,
    OP_BCAST = 2'b10,
    OP_RSVD  = 2'b11
  } xbar_op_e;

  // Source lane index chosen for one result lane.
  function automatic logic [XB_IDXW-1:0] pick_source(
    input logic [1:0]         op,
    input logic [XB_IDXW-1:0] own_lane,
    input logic [XB_IDXW-1:0] perm_i,
    input logic [XB_IDXW-1:0] bcast_i
  );
    case (op)
      OP_PERM:  return perm_i;
      OP_BCAST: return bcast_i;
      default:  return own_lane;
    endcase
  endfunction

endpackage

// File: rtl/vxbar_mux4.sv
module vxbar_mux4 #(
  parameter int unsigned W = 32
) (
  input  logic [3:0][W-1:0] d,
  input  logic [1:0]        sel,
  output logic [W-1:0]      y
);
  always_comb begin
    y = d[sel];
  end
endmodule

// File: rtl/vxbar_tree.sv
// Fixed 32:1 word selector: rank A (8 x 4:1 on idx[4:3]),
// rank B (2 x 4:1 on idx[2:1]), final 2:1 on idx[0].
module vxbar_tree #(
  parameter int unsigned W = 32
) (
  input  logic [31:0][W-1:0] src,
  input  logic [4:0]         idx,
  output logic [W-1:0]       y
);
  logic [7:0][W-1:0] rank_a;
  logic [1:0][W-1:0] rank_b;

  // Rank A group k holds source lanes k, k+8, k+16, k+24.
  for (genvar k = 0; k < 8; k++) begin : g_rank_a
    vxbar_mux4 #(.W(W)) u_mux (
      .d  ({src[k+24], src[k+16], src[k+8], src[k]}),
      .sel(idx[4:3]),
      .y  (rank_a[k])
    );
  end

  // Rank B half m holds rank A outputs m, m+2, m+4, m+6.
  for (genvar m = 0; m < 2; m++) begin : g_rank_b
    vxbar_mux4 #(.W(W)) u_mux (
      .d  ({rank_a[m+6], rank_a[m+4], rank_a[m+2], rank_a[m]}),
      .sel(idx[2:1]),
      .y  (rank_b[m])
    );
  end

  assign y = idx[0] ? rank_b[1] : rank_b[0];
endmodule

// File: rtl/vxbar_permute_xbar.sv
module vxbar_permute_xbar
  import vxbar_pkg::*;
#(
  parameter int unsigned WORD = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic                              src_sel,
  input  logic [1:0]                        opcode,
  input  logic [XB_LANES*XB_IDXW-1:0]       perm_idx,
  input  logic [XB_IDXW-1:0]                bcast_idx,
  input  logic [XB_LANES*WORD-1:0]          rf_data,
  input  logic [XB_LANES*WORD-1:0]          byp_data,
  output logic                              out_valid,
  output logic [XB_LANES*WORD-1:0]          out_data,
  output logic [(XB_LANES/2)*WORD-1:0]      fwd_even,
  output logic [(XB_LANES/2)*WORD-1:0]      fwd_odd
);
  localparam int unsigned LANES = XB_LANES;
  localparam int unsigned HALF  = LANES / 2;

  logic [LANES-1:0][WORD-1:0]    src_words;
  logic [LANES-1:0][XB_IDXW-1:0] lane_idx;
  logic [LANES-1:0][WORD-1:0]    sel_words;
  logic [LANES-1:0][WORD-1:0]    out_q;
  logic                          valid_q;
  logic                          load_evt;

  assign load_evt  = in_valid;
  assign src_words = src_sel ? byp_data : rf_data;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_idx[i] = pick_source(opcode, XB_IDXW'(i),
                                     perm_idx[i*XB_IDXW +: XB_IDXW], bcast_idx);
    vxbar_tree #(.W(WORD)) u_tree (
      .src(src_words),
      .idx(lane_idx[i]),
      .y  (sel_words[i])
    );

    // R3: tree output equals a direct index of the source lanes.
    assert_tree_index_R3: assert property (@(posedge clk) disable iff (rst)
      sel_words[i] == src_words[lane_idx[i]]);

    // R4: after a broadcast, all result lanes agree with lane 0.
    assert_bcast_uniform_R4: assert property (@(posedge clk) disable iff (rst)
      (load_evt && opcode == OP_BCAST) |=> out_q[i] == out_q[0]);

    // R2, R5: pass-through and reserved keep lanes in place.
    assert_pass_identity_R2: assert property (@(posedge clk) disable iff (rst)
      (load_evt && (opcode == OP_PASS || opcode == OP_RSVD))
        |=> out_q[i] == $past(src_words[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (load_evt) out_q <= sel_words;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = out_q;

  for (genvar k = 0; k < HALF; k++) begin : g_fwd
    assign fwd_even[k*WORD +: WORD] = out_q[2*k];
    assign fwd_odd[k*WORD +: WORD]  = out_q[2*k+1];
  end

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

// File: tb/vxbar_permute_xbar_bench.sv
module vxbar_permute_xbar_bench;
  localparam int N = 32;
  localparam int VW = N * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic src_sel = 1'b0;
  logic [1:0] opcode = 2'b00;
  logic [N*5-1:0] perm_idx = '0;
  logic [4:0] bcast_idx = '0;
  logic [VW-1:0] rf_data = '0;
  logic [VW-1:0] byp_data = '0;
  logic out_valid;
  logic [VW-1:0] out_data;
  logic [VW/2-1:0] fwd_even, fwd_odd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vxbar_permute_xbar u_vxbar_permute_xbar (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_sel(src_sel),
    .opcode(opcode), .perm_idx(perm_idx), .bcast_idx(bcast_idx),
    .rf_data(rf_data), .byp_data(byp_data), .out_valid(out_valid),
    .out_data(out_data), .fwd_even(fwd_even), .fwd_odd(fwd_odd)
  );

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int j = 0; j < N; j++) v[j*32 +: 32] = $urandom;
    return v;
  endfunction

  // Reference: lane j draws from array position given by the opcode.
  function automatic logic [VW-1:0] model(input logic [1:0] op, input logic sel,
      input logic [N*5-1:0] pv, input logic [4:0] bc,
      input logic [VW-1:0] rf, input logic [VW-1:0] byp);
    logic [31:0] lanes [N];
    logic [VW-1:0] r;
    for (int j = 0; j < N; j++) lanes[j] = sel ? byp[j*32 +: 32] : rf[j*32 +: 32];
    for (int j = 0; j < N; j++) begin
      int s;
      if (op == 2'b01) s = int'(pv[j*5 +: 5]);
      else if (op == 2'b10) s = int'(bc);
      else s = j;
      r[j*32 +: 32] = lanes[s];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [VW-1:0] exp);
    logic [VW/2-1:0] ev, od;
    for (int k = 0; k < N/2; k++) begin
      ev[k*32 +: 32] = exp[(2*k)*32 +: 32];
      od[k*32 +: 32] = exp[(2*k+1)*32 +: 32];
    end
    chk(out_data === exp, req, out_data, exp);
    chk(out_valid === 1'b1, "R7 out_valid", VW'(out_valid), VW'(1));
    chk(fwd_even === ev, "R9 fwd_even", VW'(fwd_even), VW'(ev));
    chk(fwd_odd === od, "R9 fwd_odd", VW'(fwd_odd), VW'(od));
  endtask

  // Drive one valid request at a falling edge, check one edge later.
  task automatic run(input string req, input logic [1:0] op, input logic sel,
                     input logic [N*5-1:0] pv, input logic [4:0] bc);
    logic [VW-1:0] exp;
    @(negedge clk);
    opcode = op; src_sel = sel; perm_idx = pv; bcast_idx = bc;
    rf_data = rand_vec(); byp_data = rand_vec(); in_valid = 1'b1;
    exp = model(op, sel, pv, bc, rf_data, byp_data);
    @(negedge clk);
    in_valid = 1'b0;
    check_all(req, exp);
  endtask

  function automatic logic [N*5-1:0] shuffled();
    int a [N];
    logic [N*5-1:0] pv;
    for (int j = 0; j < N; j++) a[j] = j;
    for (int j = N-1; j > 0; j--) begin
      int t, r;
      r = int'($urandom % (j+1));
      t = a[j]; a[j] = a[r]; a[r] = t;
    end
    for (int j = 0; j < N; j++) pv[j*5 +: 5] = 5'(a[j]);
    return pv;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*5-1:0] pv;
    logic [VW-1:0] held;
    void'($urandom(32'd1234));
    // R1: reset clears outputs even with valid input present
    in_valid = 1'b1; rf_data = rand_vec();
    repeat (3) @(negedge clk);
    chk(out_data === '0, "R1 out_data", out_data, '0);
    chk(out_valid === 1'b0, "R1 out_valid", VW'(out_valid), '0);
    chk(fwd_even === '0 && fwd_odd === '0, "R1 fwd", VW'(fwd_even), '0);
    rst = 1'b0; in_valid = 1'b0;

    run("R2 pass rf", 2'b00, 1'b0, '0, 5'd0);
    run("R6 pass bypass", 2'b00, 1'b1, '0, 5'd0);
    run("R5 reserved", 2'b11, 1'b0, {N{5'd7}}, 5'd9);
    for (int j = 0; j < N; j++) pv[j*5 +: 5] = 5'(N-1-j);
    run("R3 reversal", 2'b01, 1'b0, pv, 5'd0);
    run("R6 reversal bypass", 2'b01, 1'b1, pv, 5'd0);
    run("R4 broadcast lane0", 2'b10, 1'b0, '0, 5'd0);
    run("R4 broadcast lane31", 2'b10, 1'b1, '0, 5'd31);
    for (int t = 0; t < 20; t++) begin
      run("R3 random permutation", 2'b01, 1'($urandom), shuffled(), 5'd0);
      for (int j = 0; j < N; j++) pv[j*5 +: 5] = 5'($urandom);
      run("R3 random mapping", 2'b01, 1'($urandom), pv, 5'($urandom));
      run("R4 random broadcast", 2'b10, 1'($urandom), pv, 5'($urandom));
    end

    // R8: idle cycle with all other inputs scrambled keeps data
    run("R2 before hold", 2'b00, 1'b0, '0, 5'd0);
    held = out_data;
    opcode = 2'b10; bcast_idx = 5'd3; src_sel = 1'b1;
    rf_data = rand_vec(); byp_data = rand_vec(); perm_idx = shuffled();
    @(negedge clk);
    chk(out_data === held, "R8 hold data", out_data, held);
    chk(out_valid === 1'b0, "R7 valid low", VW'(out_valid), '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule